// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the architectural state changes a processor core makes when it takes a fast or normal interrupt, and when it returns from a handler. The core gives it the live status word, the program counter, and the link register and saved-status register of the current mode. The block decides whether a request is taken and presents one update with its write enables. The core's register file commits that update on the next clock edge.

On entry the block saves the old status word into the target mode's saved-status bank and the current program counter into the target mode's link register. In the same update it writes a new status word (target mode, interrupt masks set, instruction-set state forced to the fixed-length 32-bit state) and loads the handler address into the program counter. On return it writes the status word from the current mode's saved-status register and the program counter from the current mode's link register, so the interrupted mode and its masks come back in one step.

Top module: `exc_seq`

## Requirements
- R1: While reset is low, and in the first cycle after reset, busy and all write enables (`stat_we`, `saved_we`, `link_we`, `pc_we`) are 0, even when a request is held high.
- R2: A normal request sampled on an edge with the normal mask bit (status bit 7) clear and no update on the outputs produces, in the next cycle only, busy=1, all four write enables=1, `bank_fiq`=0, `saved_wd` = the sampled status word and `link_wd` = the sampled program counter.
- R3: The status word written on normal-request entry equals the sampled word with the mode field (bits 4:0) set to 5'h12, bit 7 set, bit 5 (instruction-set state) cleared, and every other bit, including bit 6, unchanged.
- R4: The status word written on fast-request entry equals the sampled word with the mode field set to 5'h11, bits 7 and 6 set, bit 5 cleared, and all other bits unchanged. `bank_fiq` is 1 during that update.
- R5: The program counter written on entry is VEC_BASE+0x18 for a normal request and VEC_BASE+0x1C for a fast request. VEC_BASE is 0 by default.
- R6: A normal request with status bit 7 set, or a fast request with status bit 6 set, causes no update for as long as the mask stays set.
- R7: When both requests are sampled unmasked, the fast request is taken. When the fast request is masked and the normal one is not, the normal request is taken.
- R8: A return strobe sampled with no update on the outputs produces, in the next cycle only, `stat_we`=1 with `stat_wd` = `cur_saved`, `pc_we`=1 with `pc_wd` = `cur_lr`, and busy, `saved_we`, `link_we` and `bank_fiq` all 0.
- R9: A return strobe and an unmasked request sampled on the same edge produce the return update. The request is evaluated again on the edge after the return cycle, against the restored status word.
- R10: Each update lasts exactly one cycle. Requests and return strobes sampled while an update is on the outputs are not acted on. A request still held afterwards is evaluated against the committed status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Normal interrupt request, level |
| fiq_req | input | 1 | Fast interrupt request, level |
| ret_req | input | 1 | Return-from-handler strobe |
| cur_stat | input | STAT_W | Live status word |
| cur_pc | input | ADDR_W | Current program counter |
| cur_lr | input | ADDR_W | Link register of the current mode |
| cur_saved | input | STAT_W | Saved-status register of the current mode |
| busy | output | 1 | Entry update on the outputs this cycle |
| stat_we | output | 1 | Status word write enable |
| stat_wd | output | STAT_W | Status word write data |
| saved_we | output | 1 | Saved-status write enable (bank given by bank_fiq) |
| saved_wd | output | STAT_W | Saved-status write data |
| link_we | output | 1 | Link register write enable (bank given by bank_fiq) |
| link_wd | output | ADDR_W | Link register write data |
| bank_fiq | output | 1 | 1 selects the fast-interrupt bank, 0 the normal bank |
| pc_we | output | 1 | Program counter write enable |
| pc_wd | output | ADDR_W | Program counter write data |

## Verification
The bench drives the block against a small model of the core's registers, so every update is committed and the next decision sees the new status. This exposes a design that re-enters on a held level request while its own update is still in flight. It also exposes one that evaluates the request alongside a return against the stale status, or acts on a return strobe that arrives during an entry. Nested entry of a fast request inside a normal handler checks that the fast mask is left untouched by normal entry and that each return picks the right bank. Simultaneous and partly masked request pairs catch a priority inversion, a wrong handler offset, or a mask bit set on the wrong entry.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_IRQ  = 2'd1,
      ACT_FIQ  = 2'd2,
      ACT_RET  = 2'd3
   } act_e;

   function automatic logic act_is_entry(input act_e a);
      return (a == ACT_IRQ) || (a == ACT_FIQ);
   endfunction

endpackage

// File: rtl/exc_req_arb.sv
module exc_req_arb
   import exc_seq_pkg::*;
#(
   parameter bit HAS_FIQ = 1'b1
) (
   input  logic irq_i,
   input  logic fiq_i,
   input  logic ret_i,
   input  logic irq_mask_i,
   input  logic fiq_mask_i,
   input  logic blocked_i,
   output act_e act_o
);

   logic irq_live;
   logic fiq_live;

   assign irq_live = irq_i & ~irq_mask_i;

   generate
      if (HAS_FIQ) begin : g_fiq
         assign fiq_live = fiq_i & ~fiq_mask_i;
      end else begin : g_nofiq
         logic unused_fiq;
         assign unused_fiq = fiq_i ^ fiq_mask_i;
         assign fiq_live   = 1'b0;
      end
   endgenerate

   always_comb begin
      act_o = ACT_NONE;
      if (!blocked_i) begin
         if (ret_i)         act_o = ACT_RET;
         else if (fiq_live) act_o = ACT_FIQ;
         else if (irq_live) act_o = ACT_IRQ;
      end
   end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
   import exc_seq_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0,
   parameter logic [ADDR_W-1:0] IRQ_OFS  = ADDR_W'('h18),
   parameter logic [ADDR_W-1:0] FIQ_OFS  = ADDR_W'('h1C)
) (
   input  act_e              act_i,
   input  logic [ADDR_W-1:0] lr_i,
   output logic [ADDR_W-1:0] pc_o
);

   localparam logic [ADDR_W-1:0] IRQ_VEC = VEC_BASE + IRQ_OFS;
   localparam logic [ADDR_W-1:0] FIQ_VEC = VEC_BASE + FIQ_OFS;

   always_comb begin
      unique case (act_i)
         ACT_IRQ: pc_o = IRQ_VEC;
         ACT_FIQ: pc_o = FIQ_VEC;
         ACT_RET: pc_o = lr_i;
         default: pc_o = '0;
      endcase
   end

endmodule

// File: rtl/exc_stat_build.sv
module exc_stat_build
   import exc_seq_pkg::*;
#(
   parameter int                STAT_W   = 32,
   parameter int                MODE_LSB = 0,
   parameter int                MODE_W   = 5,
   parameter int                T_BIT    = 5,
   parameter int                F_BIT    = 6,
   parameter int                I_BIT    = 7,
   parameter logic [MODE_W-1:0] MODE_IRQ = 5'h12,
   parameter logic [MODE_W-1:0] MODE_FIQ = 5'h11
) (
   input  act_e              act_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [STAT_W-1:0] saved_i,
   output logic [STAT_W-1:0] stat_o
);

   always_comb begin
      stat_o = stat_i;
      unique case (act_i)
         ACT_IRQ: begin
            stat_o[MODE_LSB +: MODE_W] = MODE_IRQ;
            stat_o[I_BIT]              = 1'b1;
            stat_o[T_BIT]              = 1'b0;
         end
         ACT_FIQ: begin
            stat_o[MODE_LSB +: MODE_W] = MODE_FIQ;
            stat_o[I_BIT]              = 1'b1;
            stat_o[F_BIT]              = 1'b1;
            stat_o[T_BIT]              = 1'b0;
         end
         ACT_RET: stat_o = saved_i;
         default: stat_o = stat_i;
      endcase
   end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int                STAT_W   = 32,
   parameter int                ADDR_W   = 32,
   parameter int                MODE_LSB = 0,
   parameter int                MODE_W   = 5,
   parameter int                T_BIT    = 5,
   parameter int                F_BIT    = 6,
   parameter int                I_BIT    = 7,
   parameter logic [MODE_W-1:0] MODE_IRQ = 5'h12,
   parameter logic [MODE_W-1:0] MODE_FIQ = 5'h11,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0,
   parameter logic [ADDR_W-1:0] IRQ_OFS  = ADDR_W'('h18),
   parameter logic [ADDR_W-1:0] FIQ_OFS  = ADDR_W'('h1C),
   parameter bit                HAS_FIQ  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              fiq_req,
   input  logic              ret_req,
   input  logic [STAT_W-1:0] cur_stat,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] cur_lr,
   input  logic [STAT_W-1:0] cur_saved,
   output logic              busy,
   output logic              stat_we,
   output logic [STAT_W-1:0] stat_wd,
   output logic              saved_we,
   output logic [STAT_W-1:0] saved_wd,
   output logic              link_we,
   output logic [ADDR_W-1:0] link_wd,
   output logic              bank_fiq,
   output logic              pc_we,
   output logic [ADDR_W-1:0] pc_wd
);

   localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

   generate
      if (MODE_MSB >= STAT_W) begin : g_bad_mode
         $error("exc_seq: mode field exceeds status width");
      end
      if (T_BIT >= STAT_W || F_BIT >= STAT_W || I_BIT >= STAT_W) begin : g_bad_bit
         $error("exc_seq: mask or state bit outside status word");
      end
      if ((T_BIT >= MODE_LSB && T_BIT <= MODE_MSB) ||
          (F_BIT >= MODE_LSB && F_BIT <= MODE_MSB) ||
          (I_BIT >= MODE_LSB && I_BIT <= MODE_MSB)) begin : g_bad_overlap
         $error("exc_seq: control bit overlaps mode field");
      end
      if (MODE_IRQ == MODE_FIQ) begin : g_bad_codes
         $error("exc_seq: interrupt mode codes must differ");
      end
   endgenerate

   act_e              act_d, act_q;
   logic [STAT_W-1:0] stat_d, stat_q;
   logic [STAT_W-1:0] saved_q;
   logic [ADDR_W-1:0] link_q;
   logic [ADDR_W-1:0] pc_d, pc_q;
   logic              in_flight;

   assign in_flight = (act_q != ACT_NONE);

   exc_req_arb #(
      .HAS_FIQ (HAS_FIQ)
   ) u_arb (
      .irq_i      (irq_req),
      .fiq_i      (fiq_req),
      .ret_i      (ret_req),
      .irq_mask_i (cur_stat[I_BIT]),
      .fiq_mask_i (cur_stat[F_BIT]),
      .blocked_i  (in_flight),
      .act_o      (act_d)
   );

   exc_stat_build #(
      .STAT_W   (STAT_W),
      .MODE_LSB (MODE_LSB),
      .MODE_W   (MODE_W),
      .T_BIT    (T_BIT),
      .F_BIT    (F_BIT),
      .I_BIT    (I_BIT),
      .MODE_IRQ (MODE_IRQ),
      .MODE_FIQ (MODE_FIQ)
   ) u_stat (
      .act_i   (act_d),
      .stat_i  (cur_stat),
      .saved_i (cur_saved),
      .stat_o  (stat_d)
   );

   exc_vec_gen #(
      .ADDR_W   (ADDR_W),
      .VEC_BASE (VEC_BASE),
      .IRQ_OFS  (IRQ_OFS),
      .FIQ_OFS  (FIQ_OFS)
   ) u_vec (
      .act_i (act_d),
      .lr_i  (cur_lr),
      .pc_o  (pc_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= ACT_NONE;
         stat_q  <= '0;
         saved_q <= '0;
         link_q  <= '0;
         pc_q    <= '0;
      end else begin
         act_q <= act_d;
         if (act_d != ACT_NONE) begin
            stat_q <= stat_d;
            pc_q   <= pc_d;
         end
         if (act_is_entry(act_d)) begin
            saved_q <= cur_stat;
            link_q  <= cur_pc;
         end
      end
   end

   assign busy     = act_is_entry(act_q);
   assign stat_we  = in_flight;
   assign pc_we    = in_flight;
   assign saved_we = act_is_entry(act_q);
   assign link_we  = act_is_entry(act_q);
   assign bank_fiq = (act_q == ACT_FIQ);
   assign stat_wd  = stat_q;
   assign saved_wd = saved_q;
   assign link_wd  = link_q;
   assign pc_wd    = pc_q;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
   parameter int                STAT_W   = 32,
   parameter int                ADDR_W   = 32,
   parameter int                MODE_LSB = 0,
   parameter int                MODE_W   = 5,
   parameter int                T_BIT    = 5,
   parameter int                F_BIT    = 6,
   parameter int                I_BIT    = 7,
   parameter logic [MODE_W-1:0] MODE_IRQ = 5'h12,
   parameter logic [MODE_W-1:0] MODE_FIQ = 5'h11,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0,
   parameter logic [ADDR_W-1:0] IRQ_OFS  = ADDR_W'('h18),
   parameter logic [ADDR_W-1:0] FIQ_OFS  = ADDR_W'('h1C)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic              fiq_req,
   input logic              ret_req,
   input logic [STAT_W-1:0] cur_stat,
   input logic [ADDR_W-1:0] cur_lr,
   input logic [STAT_W-1:0] cur_saved,
   input logic              busy,
   input logic              stat_we,
   input logic [STAT_W-1:0] stat_wd,
   input logic              bank_fiq,
   input logic              pc_we,
   input logic [ADDR_W-1:0] pc_wd
);

   AST_ONE_CYCLE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |=> !stat_we); // R10

   AST_IRQ_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bank_fiq) |-> !$past(cur_stat[I_BIT])); // R6

   AST_FIQ_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      bank_fiq |-> !$past(cur_stat[F_BIT])); // R6

   AST_FIQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_req && !cur_stat[F_BIT] && !ret_req && !stat_we) |=> (busy && bank_fiq)); // R7

   AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !stat_we) |=> (pc_we && !busy && pc_wd == $past(cur_lr)
                                 && stat_wd == $past(cur_saved))); // R8

   AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (stat_wd[MODE_LSB +: MODE_W] == (bank_fiq ? MODE_FIQ : MODE_IRQ)
                && stat_wd[I_BIT] && !stat_wd[T_BIT])); // R3

   AST_FIQ_SETS_F: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bank_fiq) |-> stat_wd[F_BIT]); // R4

   AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pc_wd == (bank_fiq ? VEC_BASE + FIQ_OFS : VEC_BASE + IRQ_OFS))); // R5

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!stat_we && !busy)); // R1

   logic unused_chk;
   assign unused_chk = irq_req;

endmodule

bind exc_seq exc_seq_chk #(
   .STAT_W   (STAT_W),
   .ADDR_W   (ADDR_W),
   .MODE_LSB (MODE_LSB),
   .MODE_W   (MODE_W),
   .T_BIT    (T_BIT),
   .F_BIT    (F_BIT),
   .I_BIT    (I_BIT),
   .MODE_IRQ (MODE_IRQ),
   .MODE_FIQ (MODE_FIQ),
   .VEC_BASE (VEC_BASE),
   .IRQ_OFS  (IRQ_OFS),
   .FIQ_OFS  (FIQ_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .fiq_req   (fiq_req),
   .ret_req   (ret_req),
   .cur_stat  (cur_stat),
   .cur_lr    (cur_lr),
   .cur_saved (cur_saved),
   .busy      (busy),
   .stat_we   (stat_we),
   .stat_wd   (stat_wd),
   .bank_fiq  (bank_fiq),
   .pc_we     (pc_we),
   .pc_wd     (pc_wd)
);

// File: tb/exc_seq_test.sv
`timescale 1ns/1ps
module exc_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0, fiq_req = 1'b0, ret_req = 1'b0;
   logic [31:0] cur_stat, cur_saved, cur_pc, cur_lr;
   logic        busy, stat_we, saved_we, link_we, bank_fiq, pc_we;
   logic [31:0] stat_wd, saved_wd, link_wd, pc_wd;

   // core register model
   logic [31:0] cpu_stat = 32'h33, cpu_pc = 32'h0;
   logic [31:0] sv_irq = 0, sv_fiq = 0, lr_irq = 0, lr_fiq = 0;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   string tag = "R1";

   always #2 clk = ~clk;

   exc_seq uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fiq_req(fiq_req),
      .ret_req(ret_req), .cur_stat(cur_stat), .cur_pc(cur_pc), .cur_lr(cur_lr),
      .cur_saved(cur_saved), .busy(busy), .stat_we(stat_we), .stat_wd(stat_wd),
      .saved_we(saved_we), .saved_wd(saved_wd), .link_we(link_we),
      .link_wd(link_wd), .bank_fiq(bank_fiq), .pc_we(pc_we), .pc_wd(pc_wd)
   );

   assign cur_stat  = cpu_stat;
   assign cur_pc    = cpu_pc;
   assign cur_lr    = (cpu_stat[4:0] == 5'h11) ? lr_fiq :
                      (cpu_stat[4:0] == 5'h12) ? lr_irq : 32'h0;
   assign cur_saved = (cpu_stat[4:0] == 5'h11) ? sv_fiq :
                      (cpu_stat[4:0] == 5'h12) ? sv_irq : 32'h0;

   always @(posedge clk) if (rst_n) begin
      if (stat_we) cpu_stat <= stat_wd;
      if (pc_we)   cpu_pc   <= pc_wd;
      if (saved_we) begin if (bank_fiq) sv_fiq <= saved_wd; else sv_irq <= saved_wd; end
      if (link_we)  begin if (bank_fiq) lr_fiq <= link_wd;  else lr_irq <= link_wd;  end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 none, 1 normal, 2 fast, 3 return
   int          m_kind = 0;
   logic [31:0] m_stat, m_saved, m_link, m_pc;

   function automatic logic [31:0] enter(input logic [31:0] s, input bit fast);
      logic [31:0] r;
      r = (s & ~32'h1F) | (fast ? 32'h11 : 32'h12);
      r = r | 32'h80;
      if (fast) r = r | 32'h40;
      return r & ~32'h20;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_kind = 0;
      else if (m_kind != 0) m_kind = 0;
      else if (ret_req) begin
         m_kind = 3; m_stat = cur_saved; m_pc = cur_lr;
      end else if ((fiq_req && !cur_stat[6]) || (irq_req && !cur_stat[7])) begin
         m_kind  = (fiq_req && !cur_stat[6]) ? 2 : 1;
         m_stat  = enter(cur_stat, m_kind == 2);
         m_saved = cur_stat; m_link = cur_pc;
         m_pc    = (m_kind == 2) ? 32'h1C : 32'h18;
      end else m_kind = 0;
   end

   always @(negedge clk) if (!done) begin
      logic [5:0] e_en;
      e_en = {m_kind == 1 || m_kind == 2, m_kind != 0, m_kind == 1 || m_kind == 2,
              m_kind == 1 || m_kind == 2, m_kind != 0, m_kind == 2};
      chk({busy, stat_we, saved_we, link_we, pc_we, bank_fiq} == e_en, {tag, " enables"},
          64'({busy, stat_we, saved_we, link_we, pc_we, bank_fiq}), 64'(e_en));
      if (m_kind != 0) begin
         chk(stat_wd == m_stat, {tag, " status data"}, 64'(stat_wd), 64'(m_stat));
         chk(pc_wd == m_pc, {tag, " pc data"}, 64'(pc_wd), 64'(m_pc));
      end
      if (m_kind == 1 || m_kind == 2) begin
         chk(saved_wd == m_saved, {tag, " saved data"}, 64'(saved_wd), 64'(m_saved));
         chk(link_wd == m_link, {tag, " link data"}, 64'(link_wd), 64'(m_link));
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input bit i, input bit f, input bit r);
      irq_req = i; fiq_req = f; ret_req = r;
      step();
      irq_req = 0; fiq_req = 0; ret_req = 0;
   endtask

   task automatic quiet(input string req);
      chk(!stat_we && !busy && !pc_we, req, 64'({stat_we, busy}), 64'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset quiet even with requests held
      irq_req = 1; fiq_req = 1;
      step(3); quiet("R1 in reset");
      irq_req = 0; fiq_req = 0; rst_n = 1;
      step(); quiet("R1 after reset");

      // R2 R3 R5 normal entry
      tag = "R2"; cpu_stat = 32'h33; cpu_pc = 32'h1000;
      pulse(1, 0, 0);
      chk(busy && !bank_fiq && saved_we && link_we, "R2 entry enables", 64'({busy, bank_fiq}), 64'h2);
      chk(saved_wd == 32'h33 && link_wd == 32'h1000, "R2 saved/link", 64'(saved_wd), 64'h33);
      chk(stat_wd == 32'h92, "R3 status", 64'(stat_wd), 64'h92);
      chk(pc_wd == 32'h18, "R5 normal vector", 64'(pc_wd), 64'h18);
      step(); quiet("R10 one cycle");

      // R6 held normal request while masked
      tag = "R6"; irq_req = 1; step(4); quiet("R6 masked normal"); irq_req = 0;

      // R8 return
      tag = "R8"; pulse(0, 0, 1);
      chk(stat_wd == 32'h33 && pc_wd == 32'h1000 && !saved_we && !busy, "R8 return",
          64'({stat_wd, pc_wd}), 64'h0000_0033_0000_1000);
      step(2);
      chk(cpu_stat == 32'h33 && cpu_pc == 32'h1000, "R8 restored", 64'(cpu_stat), 64'h33);

      // R6 masked fast
      tag = "R6"; cpu_stat = 32'h73; pulse(0, 1, 0); step(2); quiet("R6 masked fast");

      // R7 R4 both unmasked -> fast
      tag = "R7"; cpu_stat = 32'h33; pulse(1, 1, 0);
      chk(busy && bank_fiq, "R7 fast wins", 64'(bank_fiq), 64'h1);
      chk(stat_wd == 32'hD1, "R4 fast status", 64'(stat_wd), 64'hD1);
      chk(pc_wd == 32'h1C, "R5 fast vector", 64'(pc_wd), 64'h1C);
      step(2); tag = "R8"; pulse(0, 0, 1); step(2);

      // R7 fast masked -> normal
      tag = "R7"; cpu_stat = 32'h73; pulse(1, 1, 0);
      chk(busy && !bank_fiq && stat_wd == 32'hD2, "R7 masked fast loses", 64'(stat_wd), 64'hD2);
      step(2); tag = "R8"; pulse(0, 0, 1); step(2);

      // nesting: fast inside normal handler
      tag = "R4"; cpu_stat = 32'h33; cpu_pc = 32'h2000; pulse(1, 0, 0); step(2);
      pulse(0, 1, 0);
      chk(bank_fiq && saved_wd == 32'h92 && stat_wd == 32'hD1, "R4 nested fast",
          64'(saved_wd), 64'h92);
      step(2); tag = "R8"; pulse(0, 0, 1);
      chk(stat_wd == 32'h92 && pc_wd == 32'h18, "R8 fast bank return", 64'(stat_wd), 64'h92);
      step(2); pulse(0, 0, 1); step(2);
      chk(cpu_stat == 32'h33 && cpu_pc == 32'h2000, "R8 back to base", 64'(cpu_pc), 64'h2000);

      // R9 return with request same edge
      tag = "R9"; pulse(1, 0, 0); step(2);
      irq_req = 1; ret_req = 1; step(); ret_req = 0;
      chk(stat_we && !busy && stat_wd == 32'h33, "R9 return first", 64'({busy, stat_wd}), 64'h33);
      step(); quiet("R9 gap");
      step();
      chk(busy && saved_wd == 32'h33, "R9 re-evaluated", 64'(saved_wd), 64'h33);
      irq_req = 0; step(2); tag = "R8"; pulse(0, 0, 1); step(2);

      // R10 return strobe during entry ignored
      tag = "R10"; irq_req = 1; step(); irq_req = 0;
      chk(busy, "R10 entry", 64'(busy), 64'h1);
      ret_req = 1; step(); ret_req = 0;
      quiet("R10 strobe ignored");
      step(2);
      chk(cpu_stat == 32'h92, "R10 still in handler", 64'(cpu_stat), 64'h92);
      tag = "R8"; pulse(0, 0, 1); step(3);

      finish_run();
   end

endmodule